// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data in both directions between a narrow port A of `NW` bits and a wide port B of `2*NW` bits. Port B is made of two halves. Half 1 is bits `[NW-1:0]` and half 2 is bits `[2*NW-1:NW]`. Going from A to B, two narrow words that arrive on consecutive clock edges are gathered and presented together as one wide word. The earlier word lands in half 1 and the later word in half 2. Going from B to A, each half is captured in its own register, and a select input chooses which captured half is shown on A.

Every data register loads on the rising clock edge, and only while its own active-low capture enable is low. The half-1 path from A is two registers deep. The first stage loads on `acap1_n`. The second stage loads from the first stage on `acap2_n`, at the same edge as the half-2 register loads from A. The select input and both active-low output enables are registered, so a change on any of them is seen only after the next rising edge.

Each port is split into a data input, a data output and a drive flag. The data output always carries register contents, and the drive flag says when an outside tristate buffer should drive the pad. An asynchronous active-low reset clears every data register and turns both drive flags off.

Top module: `nw_bus_xchg`

## Requirements
- R1: While `rst_n` is low, `a_out` and `b_out` are all zeros, and `a_drv` and `b_drv` are 0.
- R2: At a rising edge with `acap1_n` low, the first A stage captures `a_in`. With `acap1_n` high, it holds its value.
- R3: At a rising edge with `acap2_n` low, two loads happen together. The half-2 register (`b_out[2*NW-1:NW]`) captures `a_in`, and the second half-1 stage (`b_out[NW-1:0]`) captures the first stage.
- R4: Suppose word W0 is on `a_in` at an edge with `acap1_n` low, and word W1 is on `a_in` at the next edge with `acap2_n` low. After that second edge, `b_out` equals `{W1, W0}`.
- R5: When `acap1_n` and `acap2_n` are both high at an edge, `b_out` does not change.
- R6: At an edge, the B-side half-1 register captures `b_in[NW-1:0]` when `bcap1_n` is low. The half-2 register captures `b_in[2*NW-1:NW]` when `bcap2_n` is low. A register whose enable is high holds its value.
- R7: `sel` is registered. After an edge where `sel` was 0, `a_out` shows the B-side half-1 register. After an edge where `sel` was 1, it shows the half-2 register.
- R8: `a_drv` is the inverse of `oe_a_n` as sampled at the most recent rising edge.
- R9: `b_drv` is the inverse of `oe_b_n` as sampled at the most recent rising edge.
- R10: The B-side enables and `b_in` have no effect on `b_out`. The A-side enables and `a_in` have no effect on `a_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | NW | Data arriving on the narrow port |
| a_out | output | NW | Selected B-side register contents toward port A |
| a_drv | output | 1 | High when port A should be driven |
| b_in | input | 2*NW | Data arriving on the wide port |
| b_out | output | 2*NW | Gathered wide word toward port B |
| b_drv | output | 1 | High when port B should be driven |
| oe_a_n | input | 1 | Active-low output enable for port A, registered |
| oe_b_n | input | 1 | Active-low output enable for port B, registered |
| sel | input | 1 | Half select for port A, registered (0: half 1, 1: half 2) |
| acap1_n | input | 1 | Active-low load for the first A stage |
| acap2_n | input | 1 | Active-low load for the second half-1 stage and the half-2 register |
| bcap1_n | input | 1 | Active-low load for the B-side half-1 register |
| bcap2_n | input | 1 | Active-low load for the B-side half-2 register |

## Verification
The bench builds the block with the default `NW = 12`, so both ports and the two 12-bit halves of B are exercised at full width with random values. At this width, words can be told apart by their bit patterns, so a half swap or an off-by-one-stage error in the A-to-B pairing shows up at once. The random enable patterns reach pipeline advances with and without the first stage being refilled. They also reach select and output-enable changes on the same edge as captures.

// File: rtl/nw_bus_xchg.sv
module nw_bus_xchg #(
  parameter int NW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NW-1:0]   a_in,
  output logic [NW-1:0]   a_out,
  output logic            a_drv,
  input  logic [2*NW-1:0] b_in,
  output logic [2*NW-1:0] b_out,
  output logic            b_drv,
  input  logic            oe_a_n,
  input  logic            oe_b_n,
  input  logic            sel,
  input  logic            acap1_n,
  input  logic            acap2_n,
  input  logic            bcap1_n,
  input  logic            bcap2_n
);
  localparam int WW = 2 * NW;

  logic [NW-1:0] a_s1, a_s2, a_h2;
  logic [NW-1:0] b_h1, b_h2;
  logic          sel_q, oea_q, oeb_q;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_s1 <= '0;
      a_s2 <= '0;
      a_h2 <= '0;
    end else begin
      if (!acap1_n) a_s1 <= a_in;
      if (!acap2_n) begin
        a_s2 <= a_s1;
        a_h2 <= a_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_h1 <= '0;
      b_h2 <= '0;
    end else begin
      if (!bcap1_n) b_h1 <= b_in[NW-1:0];
      if (!bcap2_n) b_h2 <= b_in[WW-1:NW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      oea_q <= 1'b1;
      oeb_q <= 1'b1;
      seen  <= 1'b0;
    end else begin
      sel_q <= sel;
      oea_q <= oe_a_n;
      oeb_q <= oe_b_n;
      seen  <= 1'b1;
    end
  end

  assign b_out = {a_h2, a_s2};
  assign a_out = sel_q ? b_h2 : b_h1;
  assign a_drv = ~oea_q;
  assign b_drv = ~oeb_q;

  AST_A_DRV_REG: assert property (@(posedge clk) disable iff (!rst_n) seen |-> (a_drv == !$past(oe_a_n))); // R8
  AST_B_DRV_REG: assert property (@(posedge clk) disable iff (!rst_n) seen |-> (b_drv == !$past(oe_b_n))); // R9
  AST_H2_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !acap2_n |=> (b_out[WW-1:NW] == $past(a_in))); // R3
  AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (acap1_n && acap2_n) |=> $stable(b_out)); // R5
  AST_BH1_HOLD: assert property (@(posedge clk) disable iff (!rst_n) bcap1_n |=> $stable(b_h1)); // R6
  AST_BH2_HOLD: assert property (@(posedge clk) disable iff (!rst_n) bcap2_n |=> $stable(b_h2)); // R6
endmodule

// File: tb/nw_bus_xchg_tb.sv
`timescale 1ns/1ps
module nw_bus_xchg_tb;
  localparam int NW = 12;
  localparam int WW = 2 * NW;

  logic clk = 1'b0;
  logic rst_n;
  logic [NW-1:0] a_in, a_out;
  logic [WW-1:0] b_in, b_out;
  logic a_drv, b_drv, oe_a_n, oe_b_n, sel;
  logic acap1_n, acap2_n, bcap1_n, bcap2_n;

  int n_tests = 0;
  int n_fail  = 0;

  logic [NW-1:0] m_s1, m_s2, m_h2, m_b1, m_b2;
  logic m_sel, m_oea, m_oeb;

  always #2 clk = ~clk;

  nw_bus_xchg #(.NW(NW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .sel(sel),
    .acap1_n(acap1_n), .acap2_n(acap2_n),
    .bcap1_n(bcap1_n), .bcap2_n(bcap2_n)
  );

  function automatic logic [NW-1:0] exp_a(input logic s, input logic [NW-1:0] h1, input logic [NW-1:0] h2);
    return s ? h2 : h1;
  endfunction

  function automatic logic [WW-1:0] exp_b(input logic [NW-1:0] hi, input logic [NW-1:0] lo);
    return {hi, lo};
  endfunction

  task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_s1 = '0; m_s2 = '0; m_h2 = '0; m_b1 = '0; m_b2 = '0;
    m_sel = 1'b0; m_oea = 1'b1; m_oeb = 1'b1;
  endtask

  task automatic step();
    @(posedge clk);
    if (!acap2_n) begin m_s2 = m_s1; m_h2 = a_in; end
    if (!acap1_n) m_s1 = a_in;
    if (!bcap1_n) m_b1 = b_in[NW-1:0];
    if (!bcap2_n) m_b2 = b_in[WW-1:NW];
    m_sel = sel; m_oea = oe_a_n; m_oeb = oe_b_n;
    @(negedge clk);
  endtask

  task automatic check_all();
    check("R3 b_out", b_out, exp_b(m_h2, m_s2));
    check("R7 a_out", {{NW{1'b0}}, a_out}, {{NW{1'b0}}, exp_a(m_sel, m_b1, m_b2)});
    check("R8 a_drv", {{(WW-1){1'b0}}, a_drv}, {{(WW-1){1'b0}}, !m_oea});
    check("R9 b_drv", {{(WW-1){1'b0}}, b_drv}, {{(WW-1){1'b0}}, !m_oeb});
  endtask

  task automatic idle();
    acap1_n = 1; acap2_n = 1; bcap1_n = 1; bcap2_n = 1;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [WW-1:0] held;
    logic [NW-1:0] w0, w1;
    void'($urandom(32'h5eed));
    rst_n = 0; idle();
    a_in = '1; b_in = '1; oe_a_n = 0; oe_b_n = 0; sel = 1;
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 b_out", b_out, '0);
    check("R1 a_out", {{NW{1'b0}}, a_out}, '0);
    check("R1 drv", {{(WW-2){1'b0}}, a_drv, b_drv}, '0);
    rst_n = 1; sel = 0; oe_a_n = 1; oe_b_n = 1;
    step(); check_all();

    // R4 / R2 pairing of two consecutive words
    w0 = 12'hA5C; w1 = 12'h3E1;
    a_in = w0; acap1_n = 0; oe_b_n = 0; step();
    acap1_n = 1; acap2_n = 0; a_in = w1; step();
    check("R4 pair", b_out, {w1, w0});
    check("R9 drv on", {{(WW-1){1'b0}}, b_drv}, {{(WW-1){1'b0}}, 1'b1});

    // R5 / R10 hold while B-side activity toggles
    idle(); held = b_out;
    for (int i = 0; i < 3; i++) begin
      a_in = NW'($urandom); b_in = WW'($urandom); bcap1_n = 0; bcap2_n = 0; step();
      check("R5 hold", b_out, held);
      check("R10 b_out", b_out, exp_b(m_h2, m_s2));
    end

    // R2 first stage only: second stage must then pick it up
    idle(); a_in = 12'h111; acap1_n = 0; step();
    check("R2 no advance", b_out, held);
    idle(); a_in = 12'h777; acap2_n = 0; step();
    check("R2 stage1", b_out, {12'h777, 12'h111});

    // R6 / R7 / R10: B captures, select is registered
    idle(); b_in = {12'hBBB, 12'h444}; bcap1_n = 0; bcap2_n = 0; sel = 0; oe_a_n = 0; step();
    check("R6 half1", {{NW{1'b0}}, a_out}, {{NW{1'b0}}, 12'h444});
    idle(); sel = 1; a_in = 12'h999; acap1_n = 0; acap2_n = 0;
    check("R7 before edge", {{NW{1'b0}}, a_out}, {{NW{1'b0}}, 12'h444});
    step();
    check("R7 half2", {{NW{1'b0}}, a_out}, {{NW{1'b0}}, 12'hBBB});
    check("R10 a_out", {{NW{1'b0}}, a_out}, {{NW{1'b0}}, exp_a(m_sel, m_b1, m_b2)});
    idle(); b_in = {12'h123, 12'h456}; bcap1_n = 0; step();
    check("R6 half2 held", {{NW{1'b0}}, a_out}, {{NW{1'b0}}, 12'hBBB});
    check("R8 drv", {{(WW-1){1'b0}}, a_drv}, {{(WW-1){1'b0}}, 1'b1});
    oe_a_n = 1; idle();
    check("R8 before edge", {{(WW-1){1'b0}}, a_drv}, {{(WW-1){1'b0}}, 1'b1});
    step();
    check("R8 off", {{(WW-1){1'b0}}, a_drv}, '0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      a_in = NW'($urandom); b_in = WW'($urandom);
      acap1_n = $urandom_range(0, 1) == 0;
      acap2_n = $urandom_range(0, 1) == 0;
      bcap1_n = $urandom_range(0, 2) == 0;
      bcap2_n = $urandom_range(0, 2) == 0;
      sel = 1'($urandom);
      if ($urandom_range(0, 3) == 0) oe_a_n = ~oe_a_n;
      if ($urandom_range(0, 3) == 0) oe_b_n = ~oe_b_n;
      step(); check_all();
    end

    // R1 asynchronous reset mid-run
    #1 rst_n = 0; #1;
    check("R1 async", {a_out, b_out, a_drv, b_drv}, '0);
    model_reset();
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule